// File: doc/BRIEF.md
# Interrupt Status and Enable Controller

This block gathers one-cycle event pulses from up to 24 internal resources, arranged as three groups of eight. Each group has a pending register and an enable register. An event is recorded in its pending bit only when the matching enable bit is already 1. A recorded bit then stays set until software clears it. Clearing an enable bit does not drop a pending bit; it only stops new events of that source from being recorded.

Software reaches the six registers through a simple register bus. The write port writes enable registers directly. On pending registers the write port uses write-one-to-clear: a 1 in a data bit clears that pending bit, and a 0 leaves it as it is. The read port is combinational and has no side effect. A single active-low request line is low while any pending bit anywhere is set.

Top module: `irq_status_ctrl`

## Requirements
- R1: After reset every pending bit and every enable bit is 0, and `irq_no` is 1.
- R2: An event pulse on `evt_i[8*g+b]`, in a cycle where enable bit b of group g is 1, makes pending bit b of group g read as 1 after the next rising clock edge.
- R3: An event pulse on a source whose enable bit is 0 leaves the pending registers unchanged.
- R4: A write to pending-register address g (0, 1 or 2) clears each pending bit of group g whose data bit is 1, and leaves each bit whose data bit is 0 unchanged.
- R5: If an event and a write-one clear reach the same pending bit in the same cycle, the bit is 1 afterwards.
- R6: Writing 0 to an enable bit leaves an already-pending bit of that source set.
- R7: `irq_no` is 0 exactly while at least one pending bit in any group is 1, and it updates in the same cycle as the pending registers.
- R8: Register map: addresses 0–2 read the pending registers of groups 0–2, and addresses 3–5 read and write the enable registers of groups 0–2. Addresses 6 and 7 read as 0, and writes to them have no effect.
- R9: Reading any address does not change any register.
- R10: The enable value used for an event is the one held in the register during the cycle of the event. An enable write at the same clock edge as the event does not apply to that event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| evt_i | input | 24 | Event pulses, one per source; bit 8*g+b is group g, bit b |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Write address |
| wr_data_i | input | 8 | Write data |
| rd_addr_i | input | 3 | Read address |
| rd_data_o | output | 8 | Read data (combinational) |
| irq_no | output | 1 | Interrupt request, active low |

## Verification
The bench targets these cases and the failure each one exposes:
- **Set and clear on the same bit in one cycle.** A design that lets the clear win loses an event: the bit reads 0 and the request line releases too early.
- **Disabling a source that is already pending.** A design that masks the bit at its output, instead of gating its capture, makes the pending bit disappear when the enable is cleared.
- **Enable write at the same edge as an event.** A design with the wrong ordering records an event that should have been dropped, or drops one that should have been recorded.
- **Writes of 0 to pending registers, and accesses to the unused addresses.** A design that gets these wrong changes registers it should not touch, or returns nonzero data from an unused address.

Random traffic then runs against a cycle-level model. This catches any slip in how the group slices are decoded.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int unsigned IRQ_GROUPS  = 3;
  localparam int unsigned IRQ_GROUP_W = 8;
endpackage

// File: rtl/irq_group.sv
module irq_group #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] evt_i,
  input  logic         st_clr_i,
  input  logic         en_wr_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] status_o,
  output logic [W-1:0] enable_o,
  output logic         pend_o
);
  logic [W-1:0] status_q, enable_q, hit, clr;

  assign hit = evt_i & enable_q;
  assign clr = st_clr_i ? wdata_i : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      status_q <= '0;
      enable_q <= '0;
    end else begin
      status_q <= (status_q & ~clr) | hit;  // set wins over clear
      if (en_wr_i) enable_q <= wdata_i;
    end
  end

  assign status_o = status_q;
  assign enable_o = enable_q;
  assign pend_o   = |status_q;

  a_r2_enabled_event_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_i & enable_q) != '0 |=> (status_q & $past(evt_i & enable_q)) == $past(evt_i & enable_q));

  a_r3_no_unenabled_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (status_q & ~$past(status_q) & ~$past(evt_i & enable_q)) == '0);

  a_r4_clear_only_written_ones: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (($past(status_q) & ~status_q) & ~$past(clr)) == '0);

  a_r6_enable_write_keeps_status: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_wr_i && !st_clr_i) |=> (status_q & $past(status_q)) == $past(status_q));
endmodule

// File: rtl/irq_rdmux.sv
module irq_rdmux #(
  parameter int unsigned NG = 3,
  parameter int unsigned W  = 8,
  parameter int unsigned AW = 3
) (
  input  logic [NG*W-1:0] status_i,
  input  logic [NG*W-1:0] enable_i,
  input  logic [AW-1:0]   addr_i,
  output logic [W-1:0]    data_o
);
  always_comb begin
    data_o = '0;
    for (int g = 0; g < NG; g++) begin
      if (addr_i == AW'(g))      data_o = status_i[g*W +: W];
      if (addr_i == AW'(NG + g)) data_o = enable_i[g*W +: W];
    end
  end
endmodule

// File: rtl/irq_status_ctrl.sv
module irq_status_ctrl
  import irq_pkg::*;
#(
  parameter int unsigned NG = IRQ_GROUPS,
  parameter int unsigned W  = IRQ_GROUP_W,
  localparam int unsigned NSRC = NG * W,
  localparam int unsigned AW   = $clog2(2 * NG)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [NSRC-1:0] evt_i,
  input  logic            wr_en_i,
  input  logic [AW-1:0]   wr_addr_i,
  input  logic [W-1:0]    wr_data_i,
  input  logic [AW-1:0]   rd_addr_i,
  output logic [W-1:0]    rd_data_o,
  output logic            irq_no
);
  logic [NSRC-1:0] status_all, enable_all;
  logic [NG-1:0]   pend;

  for (genvar g = 0; g < NG; g++) begin : g_grp
    logic st_clr, en_wr;
    assign st_clr = wr_en_i && (wr_addr_i == AW'(g));
    assign en_wr  = wr_en_i && (wr_addr_i == AW'(NG + g));

    irq_group #(.W(W)) u_grp (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .evt_i    (evt_i[g*W +: W]),
      .st_clr_i (st_clr),
      .en_wr_i  (en_wr),
      .wdata_i  (wr_data_i),
      .status_o (status_all[g*W +: W]),
      .enable_o (enable_all[g*W +: W]),
      .pend_o   (pend[g])
    );
  end

  irq_rdmux #(.NG(NG), .W(W), .AW(AW)) u_rdmux (
    .status_i (status_all),
    .enable_i (enable_all),
    .addr_i   (rd_addr_i),
    .data_o   (rd_data_o)
  );

  assign irq_no = ~|pend;

  a_r7_irq_tracks_status: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_no == (status_all == '0));

  a_r1_reset_state: assert property (@(posedge clk_i)
    !rst_ni |-> (irq_no && status_all == '0 && enable_all == '0));

  a_r8_unused_addr_reads_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_addr_i >= AW'(2 * NG)) |-> rd_data_o == '0);
endmodule

// File: tb/irq_status_ctrl_tb.sv
module irq_status_ctrl_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [23:0] evt_i = '0;
  logic        wr_en_i = 1'b0;
  logic [2:0]  wr_addr_i = '0;
  logic [7:0]  wr_data_i = '0;
  logic [2:0]  rd_addr_i = '0;
  logic [7:0]  rd_data_o;
  logic        irq_no;

  int tests = 0, fails = 0;
  string cur_req = "R1";
  logic [7:0] mst [3];
  logic [7:0] men [3];

  always #10 clk_i = ~clk_i;

  irq_status_ctrl u_dut (.*);

  task automatic check(string req, logic [7:0] act, logic [7:0] exp, string what);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %02h expected %02h", req, what, act, exp);
    end
  endtask

  // Full compare of all addresses and the request line (reads must be side-effect free: R9)
  task automatic compare_all();
    logic any = 1'b0;
    for (int a = 0; a < 8; a++) begin
      logic [7:0] exp;
      rd_addr_i = 3'(a);
      #1;
      exp = (a < 3) ? mst[a] : (a < 6) ? men[a-3] : 8'h00;
      check(cur_req, rd_data_o, exp, $sformatf("addr %0d", a));
    end
    for (int g = 0; g < 3; g++) any |= (mst[g] != 0);
    check(cur_req, {7'b0, irq_no}, {7'b0, ~any}, "irq_no");
  endtask

  // One clock with given inputs; model updated from pre-edge state
  task automatic step(logic [23:0] evt, logic we, logic [2:0] wa, logic [7:0] wd);
    logic [7:0] nst [3];
    logic [7:0] nen [3];
    evt_i = evt; wr_en_i = we; wr_addr_i = wa; wr_data_i = wd;
    for (int g = 0; g < 3; g++) begin
      logic [7:0] clr = (we && wa == 3'(g)) ? wd : 8'h00;
      nst[g] = (mst[g] & ~clr) | (evt[g*8 +: 8] & men[g]);
      nen[g] = (we && wa == 3'(g+3)) ? wd : men[g];
    end
    @(posedge clk_i);
    @(negedge clk_i);
    for (int g = 0; g < 3; g++) begin mst[g] = nst[g]; men[g] = nen[g]; end
    evt_i = '0; wr_en_i = 1'b0;
    compare_all();
  endtask

  initial begin
    for (int i = 0; i < 200000; i++) @(posedge clk_i);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    for (int g = 0; g < 3; g++) begin mst[g] = '0; men[g] = '0; end
    repeat (2) @(negedge clk_i);
    cur_req = "R1"; compare_all();
    rst_ni = 1'b1;
    @(negedge clk_i);
    compare_all();

    cur_req = "R8";
    step('0, 1, 3'd3, 8'hA5);
    step('0, 1, 3'd4, 8'h3C);
    step('0, 1, 3'd5, 8'hFF);
    step('0, 1, 3'd6, 8'hFF);
    step('0, 1, 3'd7, 8'h5A);

    cur_req = "R3";
    step(24'h00_C3_5A, 0, 0, 0);  // only disabled bits of groups 0/1

    cur_req = "R2";
    step(24'hFF_FF_FF, 0, 0, 0);

    cur_req = "R7";
    step('0, 0, 0, 0);

    cur_req = "R4";
    step('0, 1, 3'd0, 8'h0F);
    step('0, 1, 3'd1, 8'h00);
    step('0, 1, 3'd2, 8'hFF);

    cur_req = "R5";
    step(24'h00_00_A0, 1, 3'd0, 8'hFF);

    cur_req = "R6";
    step('0, 1, 3'd3, 8'h00);
    step(24'h00_00_FF, 0, 0, 0);

    cur_req = "R10";
    step(24'h00_00_01, 1, 3'd3, 8'h01);  // old enable 0: dropped
    step(24'h00_00_01, 1, 3'd3, 8'h00);  // old enable 1: captured

    cur_req = "R7";
    step('0, 1, 3'd0, 8'hFF);
    step('0, 1, 3'd1, 8'hFF);

    cur_req = "R9";
    repeat (3) step('0, 0, 0, 0);

    cur_req = "R2";
    for (int i = 0; i < 400; i++) begin
      logic [23:0] e = 24'($urandom) & 24'($urandom);
      logic we = ($urandom % 3) == 0;
      step(e, we, 3'($urandom), 8'($urandom));
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule